// File: doc/BRIEF.md
# Multi-Mode DMA Channel Sequencer

This block sequences one direct-memory-access channel. A peripheral asks for service on a request line. The channel then asks the bus owner for the bus through a hold request and hold acknowledge pair. Once it holds the bus, the channel runs transfer cycles. In each cycle it acknowledges the peripheral, drives the current memory address and raises one memory strobe and the opposite peripheral strobe. The data passes directly between memory and peripheral and never enters the block.

Software programs a start address, a transfer count and a mode word through a small write port. Writing a start value loads both the kept (base) copy and the working (current) copy. The mode word selects one of three transfer styles, each with its own rule for when the bus is handed back:
- single: one transfer per request, then the bus is released;
- block: back-to-back transfers that run on their own once started;
- demand: transfers that continue only while the request stays high.

The mode word also selects address direction, auto-initialization, the mask and the transfer direction. A transfer sequence ends at terminal count or on an external end-of-process input. At that point the channel either reloads its working registers from the base copies or masks itself.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, hreq, dack, tc and all four strobes are low, and the channel starts masked.
- R2: An unmasked request raises hreq in the next cycle. dack and the strobes stay low until hack is seen high, so the first transfer comes two cycles after the request when hack follows hreq by one cycle.
- R3: While the mask bit is set, dreq is ignored and hreq stays low. The mask bit is set by reset or by a mode write with bit 4 = 1.
- R4: During a transfer, dack is high and addr shows the current address. With mode bit 5 = 0, memWr and ioRd are high. With mode bit 5 = 1, memRd and ioWr are high. No strobe is high without dack.
- R5: Each transfer steps the 16-bit current address by +1, or by -1 when mode bit 2 = 1, wrapping modulo 2^16. It also decrements the current count.
- R6: Writing count value N-1 gives exactly N transfers. tc pulses high only on the transfer where the count was zero.
- R7: Single mode is mode bits [1:0] = 1 or 3. Each grant carries exactly one transfer, and hreq is low in the cycle after it.
- R8: Block mode is mode bits [1:0] = 2. dreq may fall after the first dack. Transfers then run in consecutive cycles until the sequence ends, and hreq falls after the last one.
- R9: Demand mode is mode bits [1:0] = 0. Transfers run while dreq is high, and the bus is released when dreq falls. A later request resumes at the address and count where it stopped, with no reload.
- R10: eopIn high during a transfer ends the sequence after that transfer, without a tc pulse.
- R11: At the end of a sequence, if mode bit 3 = 1 the current address and count are reloaded from the base values. Otherwise the channel sets its own mask.

Write selects on wrSel: 0 is the address, 1 is the count, 2 is the mode word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 address, 1 count, 2 mode |
| wrData | input | 16 | Write data |
| dreq | input | 1 | Peripheral service request |
| dack | output | 1 | Peripheral acknowledge, high during a transfer |
| hreq | output | 1 | Bus hold request |
| hack | input | 1 | Bus hold acknowledge |
| eopIn | input | 1 | External end-of-process |
| addr | output | 16 | Current memory address |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| ioRd | output | 1 | Peripheral read strobe |
| ioWr | output | 1 | Peripheral write strobe |
| tc | output | 1 | Terminal count pulse |

## Verification
With a bus owner that answers hreq one cycle late:
- hreq is due one cycle after dreq rises, and the first dack one cycle later.
- Block and demand transfers then follow on every cycle.
- Single-mode transfers recur every third cycle.

The bench drives inputs just after the rising edge and samples at the falling edge. It records the cycle index of every transfer, then compares each one with a cycle, address and tc value worked out from these counts. A drop of dreq or a pulse of eopIn is applied from the cycle after the transfer that triggers it, so that transfer is committed before the change takes effect.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    XFER_DEMAND = 2'd0,
    XFER_SINGLE = 2'd1,
    XFER_BLOCK  = 2'd2,
    XFER_SINGLE_ALT = 2'd3
  } xferMode_e;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_MODE  = 2'd2;

  localparam int MODE_W       = 6;
  localparam int MODE_BIT_DEC  = 2;
  localparam int MODE_BIT_AUTO = 3;
  localparam int MODE_BIT_MASK = 4;
  localparam int MODE_BIT_DIR  = 5;

  typedef struct packed {
    logic fire;
    logic endProc;
  } seqStrobe_t;

endpackage

// File: rtl/dma_seq_dp.sv
module dma_seq_dp
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  seqStrobe_t        st,
  output logic [ADDR_W-1:0] curAddr,
  output logic              countZero,
  output logic              masked,
  output xferMode_e         xferMode,
  output logic              dirRead
);

  logic [ADDR_W-1:0] baseAddr;
  logic [CNT_W-1:0]  baseCnt, curCnt;
  logic [MODE_W-1:0] modeReg;
  logic              addrDec, autoInit;
  logic [ADDR_W-1:0] nextAddr;

  always_comb begin
    xferMode  = xferMode_e'(modeReg[1:0]);
    addrDec   = modeReg[MODE_BIT_DEC];
    autoInit  = modeReg[MODE_BIT_AUTO];
    dirRead   = modeReg[MODE_BIT_DIR];
    countZero = (curCnt == '0);
    nextAddr  = addrDec ? curAddr - ADDR_W'(1) : curAddr + ADDR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      curAddr  <= '0;
      baseCnt  <= '0;
      curCnt   <= '0;
      modeReg  <= '0;
      masked   <= 1'b1;
    end else if (wrEn) begin
      case (wrSel)
        SEL_ADDR: begin
          baseAddr <= wrData[ADDR_W-1:0];
          curAddr  <= wrData[ADDR_W-1:0];
        end
        SEL_COUNT: begin
          baseCnt <= wrData[CNT_W-1:0];
          curCnt  <= wrData[CNT_W-1:0];
        end
        SEL_MODE: begin
          modeReg <= wrData[MODE_W-1:0];
          masked  <= wrData[MODE_BIT_MASK];
        end
        default: ;
      endcase
    end else if (st.fire) begin
      if (st.endProc && autoInit) begin
        curAddr <= baseAddr;
        curCnt  <= baseCnt;
      end else begin
        curAddr <= nextAddr;
        curCnt  <= curCnt - CNT_W'(1);
        if (st.endProc) masked <= 1'b1;
      end
    end
  end

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st.fire && !st.endProc && !wrEn) |=> (curCnt == CNT_W'($past(curCnt) - CNT_W'(1))));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st.fire && !st.endProc && !wrEn) |=>
      (curAddr == ($past(addrDec) ? ADDR_W'($past(curAddr) - ADDR_W'(1))
                                  : ADDR_W'($past(curAddr) + ADDR_W'(1)))));

  assert_reload_R11: assert property (@(posedge clk) disable iff (!rstN)
    (st.fire && st.endProc && autoInit && !wrEn) |=> (curAddr == baseAddr && curCnt == baseCnt));

  assert_self_mask_R11: assert property (@(posedge clk) disable iff (!rstN)
    (st.fire && st.endProc && !autoInit && !wrEn) |=> masked);

endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dreq,
  input  logic       hack,
  input  logic       eopIn,
  input  logic       masked,
  input  logic       countZero,
  input  xferMode_e  xferMode,
  output logic       hreq,
  output logic       tc,
  output seqStrobe_t st
);

  typedef enum logic {S_IDLE, S_ACTIVE} seqState_e;
  seqState_e state, stateNext;
  logic isBlock, isSingle;

  always_comb begin
    isBlock    = (xferMode == XFER_BLOCK);
    isSingle   = (xferMode == XFER_SINGLE) || (xferMode == XFER_SINGLE_ALT);
    hreq       = (state == S_ACTIVE);
    st.fire    = hreq && hack && !masked && (isBlock || dreq);
    st.endProc = st.fire && (countZero || eopIn);
    tc         = st.fire && countZero;
  end

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:   if (!masked && dreq) stateNext = S_ACTIVE;
      S_ACTIVE: begin
        if (masked)                            stateNext = S_IDLE;
        else if (st.fire && (st.endProc || isSingle)) stateNext = S_IDLE;
        else if (!isBlock && !dreq)            stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assert_tc_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    tc |=> !tc);

  assert_single_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st.fire && isSingle) |=> !hreq);

  assert_mask_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (masked && !hreq) |=> !hreq);

  assert_eop_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    st.endProc |=> !hreq);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              dreq,
  output logic              dack,
  output logic              hreq,
  input  logic              hack,
  input  logic              eopIn,
  output logic [ADDR_W-1:0] addr,
  output logic              memRd,
  output logic              memWr,
  output logic              ioRd,
  output logic              ioWr,
  output logic              tc
);

  seqStrobe_t st;
  logic       countZero, masked, dirRead;
  xferMode_e  xferMode;

  dma_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .dreq(dreq), .hack(hack), .eopIn(eopIn),
    .masked(masked), .countZero(countZero), .xferMode(xferMode),
    .hreq(hreq), .tc(tc), .st(st)
  );

  dma_seq_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .st(st), .curAddr(addr), .countZero(countZero), .masked(masked),
    .xferMode(xferMode), .dirRead(dirRead)
  );

  always_comb begin
    dack  = st.fire;
    memRd = st.fire && dirRead;
    ioWr  = st.fire && dirRead;
    memWr = st.fire && !dirRead;
    ioRd  = st.fire && !dirRead;
  end

  assert_strobe_needs_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr || ioRd || ioWr) |-> dack);

endmodule

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [15:0] wrData = '0;
  logic dreq = 1'b0, hack = 1'b0, eopIn = 1'b0;
  logic dack, hreq, memRd, memWr, ioRd, ioWr, tc;
  logic [15:0] addr;

  int nChecks = 0, nErr = 0;
  int nAck;
  bit badStrobe;
  logic [15:0] ackAddr [64];
  bit ackTc [64];
  int ackCyc [64];
  logic [3:0] ackStr [64];
  bit hreqAt [64];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) hack <= rstN && hreq;

  dma_chan_seq u_dma_chan_seq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .dreq(dreq), .dack(dack), .hreq(hreq), .hack(hack), .eopIn(eopIn),
    .addr(addr), .memRd(memRd), .memWr(memWr), .ioRd(ioRd), .ioWr(ioWr), .tc(tc)
  );

  task automatic chkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic prog(input logic [1:0] sel, input logic [15:0] data);
    @(posedge clk); #1;
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  function automatic logic [15:0] modeWord(input int xfer, input bit dec, input bit autoI,
                                           input bit mask, input bit dirRd);
    return 16'({dirRd, mask, autoI, dec, 2'(xfer)});
  endfunction

  task automatic runCap(input int maxCyc, input int dropAfter, input int eopCycle);
    nAck = 0;
    badStrobe = 1'b0;
    for (int i = 0; i <= maxCyc; i++) begin
      @(posedge clk); #1;
      if (i == 0) dreq = 1'b1;
      else if (nAck >= dropAfter) dreq = 1'b0;
      eopIn = (i == eopCycle);
      @(negedge clk);
      hreqAt[i] = hreq;
      if (dack) begin
        ackAddr[nAck] = addr;
        ackTc[nAck]   = tc;
        ackCyc[nAck]  = i;
        ackStr[nAck]  = {memRd, memWr, ioRd, ioWr};
        nAck++;
      end else if (memRd || memWr || ioRd || ioWr || tc) begin
        badStrobe = 1'b1;
      end
    end
    @(posedge clk); #1;
    dreq = 1'b0; eopIn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nErr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    int firstH;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    chkEq("R1 reset outputs", {hreq, dack, tc, memRd, memWr, ioRd, ioWr}, 0);
    // R3: reset leaves the channel masked
    runCap(6, 1000, -1);
    chkEq("R3 masked after reset, acks", nAck, 0);
    firstH = 0;
    for (int i = 0; i <= 6; i++) firstH += hreqAt[i];
    chkEq("R3 masked after reset, hreq", firstH, 0);

    // Block, increment, peripheral-to-memory, no auto-init, N=5
    prog(SEL_A(), 16'h1230);
    prog(2'd1, 16'd4);
    prog(2'd2, modeWord(2, 1'b0, 1'b0, 1'b0, 1'b0));
    runCap(12, 1, -1);
    firstH = -1;
    for (int i = 0; i <= 12; i++) if (hreqAt[i] && firstH < 0) firstH = i;
    chkEq("R2 hold request cycle", firstH, 1);
    chkEq("R2 first acknowledge cycle", ackCyc[0], 2);
    chkEq("R8 block transfer total", nAck, 5);
    for (int k = 0; k < 5; k++) begin
      chkEq("R5 block address", ackAddr[k], 16'h1230 + k);
      chkEq("R6 block tc", ackTc[k], (k == 4) ? 1 : 0);
      chkEq("R8 back-to-back cycle", ackCyc[k], 2 + k);
      chkEq("R4 write-to-memory strobes", ackStr[k], 4'b0110);
    end
    chkEq("R4 no stray strobe", badStrobe, 0);
    chkEq("R8 bus released after last", hreqAt[7], 0);
    runCap(8, 1000, -1);
    chkEq("R11 self mask without auto-init", nAck, 0);

    // Single, decrement, memory-to-peripheral, auto-init, N=4, wraps through zero
    prog(2'd0, 16'h0002);
    prog(2'd1, 16'd3);
    prog(2'd2, modeWord(1, 1'b1, 1'b1, 1'b0, 1'b1));
    runCap(24, 1000, -1);
    chkEq("R7 single transfer total", nAck, 8);
    for (int k = 0; k < 8; k++) begin
      chkEq("R7 single spacing", ackCyc[k], 2 + 3 * k);
      chkEq("R5 decrement with wrap", ackAddr[k], (2 - (k % 4)) & 16'hFFFF);
      chkEq("R6 single tc", ackTc[k], (k % 4 == 3) ? 1 : 0);
      chkEq("R4 read-from-memory strobes", ackStr[k], 4'b1001);
      chkEq("R7 bus released after grant", hreqAt[ackCyc[k] + 1], 0);
    end

    // Demand, increment, no auto-init, N=6, paused after two transfers
    prog(2'd0, 16'h8000);
    prog(2'd1, 16'd5);
    prog(2'd2, modeWord(0, 1'b0, 1'b0, 1'b0, 1'b0));
    runCap(10, 2, -1);
    chkEq("R9 demand transfers before pause", nAck, 2);
    chkEq("R9 demand second address", ackAddr[1], 16'h8001);
    chkEq("R9 no tc before pause", ackTc[0] | ackTc[1], 0);
    chkEq("R9 bus released on drop", hreqAt[10], 0);
    runCap(12, 1000, -1);
    chkEq("R9 demand resumed total", nAck, 4);
    for (int k = 0; k < 4; k++) begin
      chkEq("R9 resumed address", ackAddr[k], 16'h8002 + k);
      chkEq("R9 resumed cycle", ackCyc[k], 2 + k);
      chkEq("R6 demand tc", ackTc[k], (k == 3) ? 1 : 0);
    end

    // Block with external end-of-process on the third transfer, auto-init
    prog(2'd0, 16'h0100);
    prog(2'd1, 16'd99);
    prog(2'd2, modeWord(2, 1'b0, 1'b1, 1'b0, 1'b0));
    runCap(8, 1, 4);
    chkEq("R10 transfers up to eop", nAck, 3);
    chkEq("R10 last address", ackAddr[2], 16'h0102);
    chkEq("R10 no tc on eop", ackTc[0] | ackTc[1] | ackTc[2], 0);
    chkEq("R10 bus released after eop", hreqAt[5], 0);
    runCap(3, 1, -1);
    chkEq("R11 reload address", ackAddr[0], 16'h0100);
    chkEq("R11 reload restart cycle", ackCyc[0], 2);
    prog(2'd2, modeWord(2, 1'b0, 1'b1, 1'b1, 1'b0));
    repeat (3) @(posedge clk);
    runCap(6, 1000, -1);
    chkEq("R3 mask by mode write", nAck, 0);
    chkEq("R3 no hold while masked", hreqAt[3], 0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  function automatic logic [1:0] SEL_A();
    return 2'd0;
  endfunction

endmodule